// File: doc/BRIEF.md
# Grouped-Priority Vectored Interrupt Controller

This block picks one interrupt among several peripheral groups and hands the CPU a vector number and the matching vector-table address. Each group holds four sources and a single 4-bit priority level. Inside a group the four sources rank in a fixed order. Each source has its own 7-bit vector number, set by software.

Every cycle the block finds the highest-level pending group and the top-ranked pending source inside that group. It forwards the request only when that level beats the CPU's current interrupt mask. Its registered outputs give the request flag, the winning level, the vector and the fetch address. The fetch address is the base register plus four times the vector. An acknowledge pulse from the CPU copies the presented vector and address into a second set of outputs, which then stay fixed until the next acknowledge.

A plain write port programs three things: the base register, the priority nibbles and the vector fields.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset the base register, every priority nibble and every vector field are 0. The outputs `irq_req`, `irq_level`, `irq_vec`, `irq_addr`, `taken_vec` and `taken_addr` are all 0.
- R2: A group whose priority nibble is 0 never produces a request, whatever its pending inputs are.
- R3: Within group g, source index 4g+0 (receive error) ranks above 4g+1 (transmit error), which ranks above 4g+2 (receive data full), which ranks above 4g+3 (transmit data empty).
- R4: Among pending groups with nonzero priority, the group with the numerically highest level wins.
- R5: When groups tie on level, the group with the lowest group number wins.
- R6: `irq_req` is 1 only when the winning level is strictly greater than `cpu_mask`. A level equal to the mask does not request.
- R7: A write to address 2+k sets the vector of source 2k from data bits 14:8 and the vector of source 2k+1 from data bits 6:0. Data bits 15, 7 and 31:16 are ignored.
- R8: A write to address 0 loads the 32-bit base register. A write to address 1 loads the priority of group g from data bits 4g+3:4g.
- R9: While `irq_req` is 1, `irq_addr` equals base + 4 × `irq_vec`, taken modulo 2^32.
- R10: `irq_vec` is 8 bits wide and its bit 7 is always 0. Vectors 128 to 255 are never produced.
- R11: The outputs are registered. A change on `pending` or `cpu_mask` shows on `irq_*` exactly one clock later, and not in the same cycle.
- R12: A cycle with `ack` high copies `irq_vec` and `irq_addr` into `taken_vec` and `taken_addr` at that clock edge. Those outputs hold their value until the next `ack`.
- R13: While `irq_req` is 0, `irq_level`, `irq_vec` and `irq_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | REG_AW | Register write address |
| wr_data | input | 32 | Register write data |
| pending | input | 4×N_GRP | Pending source lines; group g uses bits 4g+3:4g |
| cpu_mask | input | 4 | CPU's current interrupt mask level |
| ack | input | 1 | Acknowledge pulse from the CPU |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_level | output | 4 | Level of the forwarded request |
| irq_vec | output | 8 | Vector number of the forwarded request |
| irq_addr | output | 32 | Vector-table fetch address |
| taken_vec | output | 8 | Vector latched at the last acknowledge |
| taken_addr | output | 32 | Fetch address latched at the last acknowledge |

## Verification
Sources are asserted one group at a time with several bit patterns: all four bits set, and the top ranks cleared one by one. This separates a correct intra-group order from a reversed or partial one. Pairs of groups with different levels and with equal levels separate level comparison from the fixed group tie-break. Sweeping the mask to exactly the winning level and to one below it exposes an off-by-one in the mask compare. Vector writes with junk in the unused bits, a vector of 127 and a change of base check the field mapping and the address sum. A last sequence of acknowledge pulses shows that the taken outputs freeze between pulses while the live outputs keep following.

// File: rtl/pvi_pkg.sv
package pvi_pkg;
  localparam int unsigned PRIO_W = 4;
  localparam int unsigned VEC_W  = 7;
  localparam int unsigned SUB_N  = 4;
  localparam int unsigned ADDR_W = 32;

  typedef enum logic [1:0] {
    SUB_RX_ERR   = 2'd0,
    SUB_TX_ERR   = 2'd1,
    SUB_RX_FULL  = 2'd2,
    SUB_TX_EMPTY = 2'd3
  } sub_e;

  // Vector-table slot: base plus four bytes per vector.
  function automatic logic [ADDR_W-1:0] fetch_address(
    input logic [ADDR_W-1:0] base,
    input logic [VEC_W-1:0]  vec
  );
    return base + {{(ADDR_W-VEC_W-2){1'b0}}, vec, 2'b00};
  endfunction

  // Lowest set bit wins; bit 0 is the highest rank.
  function automatic logic [1:0] first_pending(input logic [SUB_N-1:0] p);
    logic [1:0] s;
    s = 2'd0;
    for (int i = SUB_N - 1; i >= 0; i--) begin
      if (p[i]) s = 2'(i);
    end
    return s;
  endfunction
endpackage

// File: rtl/pvi_regfile.sv
module pvi_regfile
  import pvi_pkg::*;
#(
  parameter int unsigned N_GRP  = 3,
  parameter int unsigned REG_AW = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [REG_AW-1:0]         wr_addr,
  input  logic [31:0]               wr_data,
  output logic [ADDR_W-1:0]         base_q,
  output logic [N_GRP*PRIO_W-1:0]   prio_q,
  output logic [N_GRP*SUB_N*VEC_W-1:0] vec_q
);
  localparam int unsigned N_SRC  = N_GRP * SUB_N;
  localparam int unsigned N_VREG = N_SRC / 2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      prio_q <= '0;
      vec_q  <= '0;
    end else if (wr_en) begin
      if (int'(wr_addr) == 0) base_q <= wr_data;
      if (int'(wr_addr) == 1) begin
        for (int g = 0; g < N_GRP; g++)
          prio_q[g*PRIO_W +: PRIO_W] <= wr_data[g*PRIO_W +: PRIO_W];
      end
      for (int k = 0; k < N_VREG; k++) begin
        if (int'(wr_addr) == 2 + k) begin
          vec_q[(2*k)*VEC_W   +: VEC_W] <= wr_data[14:8];
          vec_q[(2*k+1)*VEC_W +: VEC_W] <= wr_data[6:0];
        end
      end
    end
  end
endmodule

// File: rtl/pvi_group_sel.sv
module pvi_group_sel
  import pvi_pkg::*;
(
  input  logic [PRIO_W-1:0] prio,
  input  logic [SUB_N-1:0]  pend,
  output logic              req,
  output logic [PRIO_W-1:0] level,
  output logic [1:0]        sub
);
  assign req   = (prio != '0) && (|pend);
  assign level = prio;
  assign sub   = first_pending(pend);
endmodule

// File: rtl/pvi_arbiter.sv
module pvi_arbiter
  import pvi_pkg::*;
#(
  parameter int unsigned N_GRP = 3,
  localparam int unsigned GI_W = (N_GRP > 1) ? $clog2(N_GRP) : 1
) (
  input  logic [N_GRP-1:0]        grp_req,
  input  logic [N_GRP*PRIO_W-1:0] grp_level,
  input  logic [N_GRP*2-1:0]      grp_sub,
  input  logic [PRIO_W-1:0]       cpu_mask,
  output logic                    fwd,
  output logic [PRIO_W-1:0]       win_level,
  output logic [GI_W-1:0]         win_grp,
  output logic [1:0]              win_sub
);
  always_comb begin
    win_level = '0;
    win_grp   = '0;
    win_sub   = '0;
    // Ascending scan with strict compare: ties stay with the lower group.
    for (int g = 0; g < N_GRP; g++) begin
      if (grp_req[g] && (grp_level[g*PRIO_W +: PRIO_W] > win_level)) begin
        win_level = grp_level[g*PRIO_W +: PRIO_W];
        win_grp   = GI_W'(g);
        win_sub   = grp_sub[g*2 +: 2];
      end
    end
    fwd = (win_level > cpu_mask);
  end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import pvi_pkg::*;
#(
  parameter int unsigned N_GRP  = 3,
  parameter int unsigned REG_AW = 4,
  localparam int unsigned N_SRC = N_GRP * SUB_N,
  localparam int unsigned GI_W  = (N_GRP > 1) ? $clog2(N_GRP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [N_SRC-1:0]  pending,
  input  logic [3:0]        cpu_mask,
  input  logic              ack,
  output logic              irq_req,
  output logic [3:0]        irq_level,
  output logic [7:0]        irq_vec,
  output logic [31:0]       irq_addr,
  output logic [7:0]        taken_vec,
  output logic [31:0]       taken_addr
);
  localparam int unsigned SRC_W = GI_W + 2;

  logic [ADDR_W-1:0]        base_q;
  logic [N_GRP*PRIO_W-1:0]  prio_q;
  logic [N_SRC*VEC_W-1:0]   vec_q;

  logic [N_GRP-1:0]         grp_req;
  logic [N_GRP*PRIO_W-1:0]  grp_level;
  logic [N_GRP*2-1:0]       grp_sub;

  // Named internal events for the checker.
  logic                     win_fwd;
  logic [PRIO_W-1:0]        win_level;
  logic [GI_W-1:0]          win_grp;
  logic [1:0]               win_sub;
  logic [SRC_W-1:0]         win_src;
  logic [VEC_W-1:0]         win_vec;

  pvi_regfile #(.N_GRP(N_GRP), .REG_AW(REG_AW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .base_q  (base_q),
    .prio_q  (prio_q),
    .vec_q   (vec_q)
  );

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    pvi_group_sel u_sel (
      .prio  (prio_q[g*PRIO_W +: PRIO_W]),
      .pend  (pending[g*SUB_N +: SUB_N]),
      .req   (grp_req[g]),
      .level (grp_level[g*PRIO_W +: PRIO_W]),
      .sub   (grp_sub[g*2 +: 2])
    );
  end

  pvi_arbiter #(.N_GRP(N_GRP)) u_arb (
    .grp_req   (grp_req),
    .grp_level (grp_level),
    .grp_sub   (grp_sub),
    .cpu_mask  (cpu_mask),
    .fwd       (win_fwd),
    .win_level (win_level),
    .win_grp   (win_grp),
    .win_sub   (win_sub)
  );

  // Four sources per group, so the flat index is {group, sub}.
  assign win_src = {win_grp, win_sub};

  always_comb begin
    win_vec = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (int'(win_src) == i) win_vec = vec_q[i*VEC_W +: VEC_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req    <= 1'b0;
      irq_level  <= '0;
      irq_vec    <= '0;
      irq_addr   <= '0;
      taken_vec  <= '0;
      taken_addr <= '0;
    end else begin
      if (win_fwd) begin
        irq_req   <= 1'b1;
        irq_level <= win_level;
        irq_vec   <= {1'b0, win_vec};
        irq_addr  <= fetch_address(base_q, win_vec);
      end else begin
        irq_req   <= 1'b0;
        irq_level <= '0;
        irq_vec   <= '0;
        irq_addr  <= '0;
      end
      if (ack) begin
        taken_vec  <= irq_vec;
        taken_addr <= irq_addr;
      end
    end
  end
endmodule

// File: rtl/pvi_checker.sv
module pvi_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  cpu_mask,
  input logic        ack,
  input logic        irq_req,
  input logic [3:0]  irq_level,
  input logic [7:0]  irq_vec,
  input logic [31:0] irq_addr,
  input logic [7:0]  taken_vec,
  input logic [31:0] taken_addr,
  input logic [31:0] base_q,
  input logic        win_fwd
);
  p_nonzero_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_level != 4'd0);

  p_above_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_level > $past(cpu_mask));

  p_fetch_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_addr == $past(base_q) + {23'd0, irq_vec[6:0], 2'b00});

  p_vec_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_vec[7] == 1'b0);

  p_fwd_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    win_fwd |=> irq_req);

  p_fwd_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !win_fwd |=> !irq_req);

  p_take_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (taken_vec == $past(irq_vec)) && (taken_addr == $past(irq_addr)));

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> $stable(taken_vec) && $stable(taken_addr));

  p_idle_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_level == 4'd0) && (irq_vec == 8'd0) && (irq_addr == 32'd0));
endmodule

bind prio_vec_intc pvi_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_mask   (cpu_mask),
  .ack        (ack),
  .irq_req    (irq_req),
  .irq_level  (irq_level),
  .irq_vec    (irq_vec),
  .irq_addr   (irq_addr),
  .taken_vec  (taken_vec),
  .taken_addr (taken_addr),
  .base_q     (base_q),
  .win_fwd    (win_fwd)
);

// File: tb/prio_vec_intc_test.sv
`timescale 1ns/1ps
module prio_vec_intc_test;
  localparam int NG = 3;
  localparam int NS = NG * 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [NS-1:0] pending = '0;
  logic [3:0]  cpu_mask = '0;
  logic        ack = 1'b0;
  logic        irq_req;
  logic [3:0]  irq_level;
  logic [7:0]  irq_vec;
  logic [31:0] irq_addr;
  logic [7:0]  taken_vec;
  logic [31:0] taken_addr;

  always #2 clk = ~clk;

  prio_vec_intc #(.N_GRP(NG), .REG_AW(4)) uut (.*);

  int n_run = 0;
  int n_fail = 0;

  int          m_prio [NG];
  int          m_vec  [NS];
  logic [31:0] m_base;

  typedef struct {
    string       tag;
    bit          req;
    int          lvl;
    int          vec;
    logic [31:0] addr;
  } item_t;

  item_t sb_q[$];
  event  chk_ev;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic item_t model(string tag);
    item_t it;
    int best = 0;
    int bg = -1;
    int bs = 0;
    for (int g = 0; g < NG; g++) begin
      if (m_prio[g] != 0 && pending[4*g +: 4] != 4'b0 && m_prio[g] > best) begin
        best = m_prio[g];
        bg = g;
        bs = 3;
        for (int s = 3; s >= 0; s--) if (pending[4*g+s]) bs = s;
      end
    end
    it.tag = tag; it.req = 0; it.lvl = 0; it.vec = 0; it.addr = 32'd0;
    if (bg >= 0 && best > int'(cpu_mask)) begin
      it.req = 1;
      it.lvl = best;
      it.vec = m_vec[bg*4 + bs];
      it.addr = m_base + 32'(it.vec * 4);
    end
    return it;
  endfunction

  task automatic wr(int addr, logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(addr); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
    if (addr == 0) m_base = data;
    else if (addr == 1) for (int g = 0; g < NG; g++) m_prio[g] = int'(data[4*g +: 4]);
    else if (addr >= 2 && addr < 2 + NS/2) begin
      m_vec[2*(addr-2)]   = int'(data[14:8]);
      m_vec[2*(addr-2)+1] = int'(data[6:0]);
    end
  endtask

  task automatic drive(string tag, logic [NS-1:0] p, logic [3:0] m);
    @(negedge clk);
    pending = p; cpu_mask = m;
    sb_q.push_back(model(tag));
    @(negedge clk);
    ->chk_ev;
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        check({it.tag, " req"},   64'(irq_req),   64'(it.req));
        check({it.tag, " level"}, 64'(irq_level), 64'(it.lvl));
        check({it.tag, " vec"},   64'(irq_vec),   64'(it.vec));
        check({it.tag, " addr"},  64'(irq_addr),  64'(it.addr));
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0]  t_vec;
    logic [31:0] t_addr;
    m_base = 32'd0;
    for (int g = 0; g < NG; g++) m_prio[g] = 0;
    for (int i = 0; i < NS; i++) m_vec[i] = 0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq_req",    64'(irq_req), 64'd0);
    check("R1 irq_addr",   64'(irq_addr), 64'd0);
    check("R1 taken_vec",  64'(taken_vec), 64'd0);
    check("R1 taken_addr", 64'(taken_addr), 64'd0);
    // R1/R2: priorities reset to 0, so nothing requests
    drive("R1 R2 all pending at reset", '1, 4'd0);
    drive("R2 clear", '0, 4'd0);

    // R7/R8: program base, vectors (junk in ignored bits), priorities
    wr(0, 32'h0000_1000);
    for (int k = 0; k < NS/2; k++) begin
      logic [6:0] a = 7'((k*2*37 + 5) % 128);
      logic [6:0] b = 7'(((k*2+1)*37 + 5) % 128);
      wr(2 + k, {16'hA5A5, 1'b1, a, 1'b1, b});
    end
    wr(1, 32'hFFFF_F595);   // g0=5, g1=9, g2=5

    // R3 intra-group order
    drive("R3 g0 all four",       12'h00F, 4'd0);
    drive("R3 g0 tx err down",    12'h00E, 4'd0);
    drive("R3 g0 rx full down",   12'h00C, 4'd0);
    drive("R3 g0 tx empty only",  12'h008, 4'd0);
    drive("R3 g0 err+full",       12'h006, 4'd0);
    drive("R7 g1 src 4",          12'h010, 4'd0);
    // R4 level compare
    drive("R4 g0 vs g1",          12'h0F1, 4'd0);
    drive("R4 g2 vs g1",          12'h840, 4'd0);
    // R5 tie break
    drive("R5 g0 vs g2 tie",      12'h104, 4'd0);
    drive("R5 g2 alone",          12'h200, 4'd0);
    // R6 mask strictly below
    drive("R6 mask equal",        12'h001, 4'd5);
    drive("R6 mask one below",    12'h001, 4'd4);
    drive("R6 g1 mask equal",     12'h020, 4'd9);
    drive("R6 g1 mask 8",         12'h020, 4'd8);
    drive("R13 idle zeros",       12'h000, 4'd0);
    // R2 level 0 masks group
    wr(1, 32'h0000_0505);
    drive("R2 g1 level 0",        12'h0F0, 4'd0);
    drive("R2 g1 zero g0 wins",   12'h0F1, 4'd0);
    // R8 R9 base change, R10 vector 127
    wr(0, 32'hFFFF_FF00);
    wr(2 + 5, 32'h0000_7F00);    // src 10 = 127, src 11 = 0
    drive("R9 R10 vec 127 wrap",  12'h400, 4'd0);
    drive("R7 src 11 vec 0",      12'h800, 4'd0);
    wr(0, 32'h8000_0000);
    drive("R8 R9 new base",       12'h400, 4'd0);

    // R11 one-cycle latency
    drive("R11 setup", 12'h000, 4'd0);
    @(negedge clk);
    pending = 12'h002;
    #1;
    check("R11 same cycle req", 64'(irq_req), 64'd0);
    @(negedge clk);
    check("R11 next cycle req", 64'(irq_req), 64'd1);
    check("R11 next cycle vec", 64'(irq_vec), 64'(m_vec[1]));

    // R12 acknowledge latching
    t_vec  = irq_vec;
    t_addr = irq_addr;
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    check("R12 taken vec",  64'(taken_vec),  64'(t_vec));
    check("R12 taken addr", 64'(taken_addr), 64'(t_addr));
    pending = 12'h004;
    repeat (2) @(negedge clk);
    check("R12 live follows", 64'(irq_vec),   64'(m_vec[2]));
    check("R12 taken holds",  64'(taken_vec), 64'(t_vec));
    check("R12 addr holds",   64'(taken_addr), 64'(t_addr));
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    check("R12 second ack", 64'(taken_vec), 64'(m_vec[2]));
    check("R12 second addr", 64'(taken_addr), 64'(32'h8000_0000 + 32'(m_vec[2]*4)));

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule